// File: doc/BRIEF.md
# Serial ADC Frame Generator

This block is a synthesizable device-side model of a 10-bit serial converter's output port. It serves as a peer for a host-side serial reader in a testbench or as a stand-in for the converter in an emulation build. It runs on a fast system clock and oversamples two pins driven by the host: an active-low select and a serial clock that idles low. Both pass through synchronizers, and edges are found on the synchronized levels.

A falling edge on the select latches the parallel sample inputs (data word, channel bit and sub-bits) and wakes the model. The output line is then driven high until the first falling serial clock edge. Each later falling edge presents the next frame bit, most significant first: three constant ones, the channel bit, the data word and then the sub-bits. Once the frame is used up, the line carries zeros. Raising the select at any point aborts the read and returns the port to shutdown, with its output released. A parameter selects a single-channel variant, whose channel bit is always one.

Top module: `sadc_frame_gen`

## Requirements
- R1: While the synchronized select is high (and out of reset), `sdo_en` is 0 (output released), `awake` is 0 and `bit_cnt` is 0.
- R2: After a select falling edge and before any falling serial clock edge, `sdo_en` = 1, `awake` = 1, `sdo_d` = 1 and `bit_cnt` = 0. The sample inputs are captured at that point, and later changes to them do not alter the frame.
- R3: Each falling serial clock edge while selected drives the next bit of the 16-bit frame {1,1,1,chid,data[9..0],sub[1],sub[0]}, sent left to right, and raises `bit_cnt` by one. The k-th edge gives bit k, with `bit_cnt` = k.
- R4: The first three bits of every frame are 1.
- R5: Falling edges after the sixteenth drive 0 on `sdo_d`, and `bit_cnt` stays at 16.
- R6: Raising the select before the frame ends aborts the read: `sdo_en`, `awake` and `bit_cnt` return to 0. The next selection captures a fresh sample and restarts at bit 1.
- R7: Rising serial clock edges leave `sdo_d` and `bit_cnt` unchanged. Serial clock edges while deselected have no effect, so the next frame still starts at bit 1.
- R8: With `DUAL_CHANNEL` = 0 the channel bit (frame bit 4) is always 1, whatever `sample_chan` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| sample_data | input | DATA_W | Conversion result captured at selection |
| sample_chan | input | 1 | Channel bit captured at selection |
| sample_sub | input | SUB_W | Sub-bits captured at selection |
| sdo_d | output | 1 | Serial output data value |
| sdo_en | output | 1 | Output drive enable; 0 means high impedance |
| awake | output | 1 | Power flag: 1 when active, 0 in shutdown |
| bit_cnt | output | CNT_W | Frame bits already shifted, saturating at FRAME_W |

## Verification
Frames are read with all-ones data on channel 0 with sub-bits 00, and with all-zero data on channel 1 with sub-bits 11. These show whether the constant ones, the channel bit and the sub-bits come from their own slots rather than from the data word. Two alternating data patterns (0x2A5 and 0x15A) with mixed sub-bits expose any off-by-one shift or swapped bit. Between the edge that captures the sample and the first shift, the sample inputs are inverted, which separates a captured sample from a live one. An aborted read, serial clocks while deselected, and a second instance in the single-channel variant fed the same inputs cover the shutdown, restart and channel-bit rules.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
   // power state of the modelled port
   typedef enum logic {
      PWR_OFF = 1'b0,
      PWR_ON  = 1'b1
   } pwr_e;

   // total bits in one frame: constant ones, channel bit, data, sub-bits
   function automatic int frame_bits(input int lead, input int data_w, input int sub_w);
      return lead + 1 + data_w + sub_w;
   endfunction
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] ff_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '1;
            else        ff_q <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '1;
            else        ff_q <= {ff_q[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/sadc_fall_det.sv
module sadc_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl;
   end

   assign fall = prev_q & ~lvl;
endmodule

// File: rtl/sadc_frame_pack.sv
module sadc_frame_pack #(
   parameter int DATA_W       = 10,
   parameter int SUB_W        = 2,
   parameter int LEAD_ONES    = 3,
   parameter int DUAL_CHANNEL = 1,
   parameter int FRAME_W      = 16
) (
   input  logic [DATA_W-1:0]  data,
   input  logic               chan,
   input  logic [SUB_W-1:0]   sub,
   output logic [FRAME_W-1:0] frame
);
   logic chid;

   generate
      if (DUAL_CHANNEL != 0) begin : g_dual
         assign chid = chan;
      end else begin : g_single
         logic unused_chan;
         assign unused_chan = chan;
         assign chid        = 1'b1;
      end
   endgenerate

   assign frame = {{LEAD_ONES{1'b1}}, chid, data, sub};
endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter
   import sadc_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               desel,
   input  logic               start,
   input  logic               shift,
   input  logic [FRAME_W-1:0] frame_in,
   output logic               sdo_d,
   output logic               sdo_en,
   output logic               awake,
   output logic [CNT_W-1:0]   bit_cnt
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   pwr_e               pwr_q;
   logic [FRAME_W-1:0] shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q   <= PWR_OFF;
         shreg_q <= '0;
         sdo_d   <= 1'b1;
         sdo_en  <= 1'b0;
         bit_cnt <= '0;
      end else if (desel) begin
         // shutdown: release the line and forget any partial frame
         pwr_q   <= PWR_OFF;
         shreg_q <= '0;
         sdo_d   <= 1'b1;
         sdo_en  <= 1'b0;
         bit_cnt <= '0;
      end else if (start) begin
         pwr_q   <= PWR_ON;
         shreg_q <= frame_in;
         sdo_d   <= 1'b1;
         sdo_en  <= 1'b1;
         bit_cnt <= '0;
      end else if (shift && (pwr_q == PWR_ON)) begin
         // zeros refill from the right, so the tail is zero by itself
         sdo_d   <= shreg_q[FRAME_W-1];
         shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
         if (bit_cnt != CNT_FULL) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign awake = (pwr_q == PWR_ON);
endmodule

// File: rtl/sadc_frame_gen.sv
module sadc_frame_gen
   import sadc_pkg::*;
#(
   parameter int  DATA_W       = 10,
   parameter int  SUB_W        = 2,
   parameter int  LEAD_ONES    = 3,
   parameter int  DUAL_CHANNEL = 1,
   parameter int  SYNC_STAGES  = 2,
   localparam int FRAME_W      = frame_bits(LEAD_ONES, DATA_W, SUB_W),
   localparam int CNT_W        = $clog2(FRAME_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic [DATA_W-1:0] sample_data,
   input  logic              sample_chan,
   input  logic [SUB_W-1:0]  sample_sub,
   output logic              sdo_d,
   output logic              sdo_en,
   output logic              awake,
   output logic [CNT_W-1:0]  bit_cnt
);
   // elaboration-time parameter checks
   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("sadc_frame_gen: DATA_W must be at least 1");
      end
      if (SUB_W < 1) begin : g_bad_sub
         $error("sadc_frame_gen: SUB_W must be at least 1");
      end
      if (LEAD_ONES < 1) begin : g_bad_lead
         $error("sadc_frame_gen: LEAD_ONES must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("sadc_frame_gen: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic               cs_s;
   logic               sclk_s;
   logic               cs_fall;
   logic               sclk_fall;
   logic [FRAME_W-1:0] frame;

   sadc_sync #(.STAGES(SYNC_STAGES)) u_sync_cs (
      .clk (clk),
      .rst_n (rst_n),
      .din (cs_n),
      .dout (cs_s)
   );

   sadc_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
      .clk (clk),
      .rst_n (rst_n),
      .din (sclk),
      .dout (sclk_s)
   );

   sadc_fall_det u_fall_cs (
      .clk (clk),
      .rst_n (rst_n),
      .lvl (cs_s),
      .fall (cs_fall)
   );

   sadc_fall_det u_fall_sclk (
      .clk (clk),
      .rst_n (rst_n),
      .lvl (sclk_s),
      .fall (sclk_fall)
   );

   sadc_frame_pack #(
      .DATA_W (DATA_W),
      .SUB_W (SUB_W),
      .LEAD_ONES (LEAD_ONES),
      .DUAL_CHANNEL (DUAL_CHANNEL),
      .FRAME_W (FRAME_W)
   ) u_pack (
      .data (sample_data),
      .chan (sample_chan),
      .sub (sample_sub),
      .frame (frame)
   );

   sadc_shifter #(
      .FRAME_W (FRAME_W),
      .CNT_W (CNT_W)
   ) u_shift (
      .clk (clk),
      .rst_n (rst_n),
      .desel (cs_s),
      .start (cs_fall),
      .shift (sclk_fall),
      .frame_in (frame),
      .sdo_d (sdo_d),
      .sdo_en (sdo_en),
      .awake (awake),
      .bit_cnt (bit_cnt)
   );
endmodule

// File: rtl/sadc_chk.sv
module sadc_chk #(
   parameter int FRAME_W      = 16,
   parameter int LEAD_ONES    = 3,
   parameter int DUAL_CHANNEL = 1,
   parameter int CNT_W        = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sdo_d,
   input logic             sdo_en,
   input logic             awake,
   input logic [CNT_W-1:0] bit_cnt
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] LEAD = CNT_W'(LEAD_ONES);
   localparam logic [CNT_W-1:0] CHID = CNT_W'(LEAD_ONES + 1);

   // R1
   drive_needs_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_en |-> awake);

   // R1
   idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !awake |-> (bit_cnt == '0));

   // R2
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_en && bit_cnt == '0) |-> sdo_d);

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_en && $past(sdo_en)) |->
         (bit_cnt == $past(bit_cnt) || bit_cnt == $past(bit_cnt) + 1'b1));

   // R4
   lead_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_en && bit_cnt != '0 && bit_cnt <= LEAD) |-> sdo_d);

   // R5
   count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= FULL);

   // R5
   tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_en && bit_cnt == FULL && $past(bit_cnt) == FULL && sdo_d != $past(sdo_d))
         |-> !sdo_d);

   generate
      if (DUAL_CHANNEL == 0) begin : g_single
         // R8
         single_chid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sdo_en && bit_cnt == CHID) |-> sdo_d);
      end
   endgenerate
endmodule

bind sadc_frame_gen sadc_chk #(
   .FRAME_W (FRAME_W),
   .LEAD_ONES (LEAD_ONES),
   .DUAL_CHANNEL (DUAL_CHANNEL),
   .CNT_W (CNT_W)
) u_sadc_chk (
   .clk (clk),
   .rst_n (rst_n),
   .sdo_d (sdo_d),
   .sdo_en (sdo_en),
   .awake (awake),
   .bit_cnt (bit_cnt)
);

// File: tb/test_sadc_frame_gen.sv
module test_sadc_frame_gen;
   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic       rst_n, cs_n, sclk, chan;
   logic [9:0] data;
   logic [1:0] sub;
   logic       d_dual, e_dual, a_dual;
   logic [4:0] c_dual;
   logic       d_sgl, e_sgl, a_sgl;
   logic [4:0] c_sgl;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   sadc_frame_gen i_sadc_frame_gen (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk),
      .sample_data (data), .sample_chan (chan), .sample_sub (sub),
      .sdo_d (d_dual), .sdo_en (e_dual), .awake (a_dual), .bit_cnt (c_dual)
   );

   sadc_frame_gen #(.DUAL_CHANNEL(0)) i_sadc_frame_gen_single (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk),
      .sample_data (data), .sample_chan (chan), .sample_sub (sub),
      .sdo_d (d_sgl), .sdo_en (e_sgl), .awake (a_sgl), .bit_cnt (c_sgl)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sclk_rise;
      sclk = 1'b1;
      wait_clk(8);
   endtask

   task automatic sclk_fall;
      sclk = 1'b0;
      wait_clk(8);
   endtask

   task automatic select(input logic [9:0] d, input logic c, input logic [1:0] s);
      data = d; chan = c; sub = s;
      cs_n = 1'b0;
      wait_clk(8);
   endtask

   task automatic deselect;
      cs_n = 1'b1;
      wait_clk(8);
   endtask

   function automatic logic [15:0] exp_frame(input logic [9:0] d, input logic c,
                                             input logic [1:0] s);
      return {3'b111, c, d, s};
   endfunction

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0;
      data = '0; chan = 1'b0; sub = '0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(8);
      chk("R1", "reset sdo_en", int'(e_dual), 0);
      chk("R1", "reset awake", int'(a_dual), 0);
      chk("R1", "reset bit_cnt", int'(c_dual), 0);
      chk("R1", "reset single sdo_en", int'(e_sgl), 0);
   endtask

   task automatic t_frame(input logic [9:0] d, input logic c, input logic [1:0] s);
      logic [15:0] fd, fs;
      fd = exp_frame(d, c, s);
      fs = exp_frame(d, 1'b1, s);
      select(d, c, s);
      chk("R2", "selected sdo_en", int'(e_dual), 1);
      chk("R2", "selected awake", int'(a_dual), 1);
      chk("R2", "pre-clock sdo_d", int'(d_dual), 1);
      chk("R2", "pre-clock bit_cnt", int'(c_dual), 0);
      // inputs move after capture; the frame must not follow them (R2)
      data = ~d; chan = ~c; sub = ~s;
      for (int k = 1; k <= 16; k++) begin
         sclk_rise;
         chk("R7", "bit_cnt after rising edge", int'(c_dual), k - 1);
         sclk_fall;
         chk((k <= 3) ? "R4" : "R3", $sformatf("frame bit %0d", k), int'(d_dual),
             int'(fd[16-k]));
         chk("R3", $sformatf("bit_cnt at bit %0d", k), int'(c_dual), k);
         if (k == 4) chk("R8", "single variant channel bit", int'(d_sgl), 1);
         else        chk("R3", $sformatf("single frame bit %0d", k), int'(d_sgl),
                         int'(fs[16-k]));
      end
      for (int k = 0; k < 3; k++) begin
         sclk_rise;
         sclk_fall;
         chk("R5", "tail bit", int'(d_dual), 0);
         chk("R5", "tail bit_cnt", int'(c_dual), 16);
      end
      deselect;
      chk("R1", "deselected sdo_en", int'(e_dual), 0);
      chk("R1", "deselected awake", int'(a_dual), 0);
      chk("R1", "deselected bit_cnt", int'(c_dual), 0);
   endtask

   task automatic t_abort;
      select(10'h155, 1'b1, 2'b01);
      for (int k = 0; k < 5; k++) begin
         sclk_rise;
         sclk_fall;
      end
      chk("R6", "bit_cnt before abort", int'(c_dual), 5);
      deselect;
      chk("R6", "abort sdo_en", int'(e_dual), 0);
      chk("R6", "abort awake", int'(a_dual), 0);
      chk("R6", "abort bit_cnt", int'(c_dual), 0);
      // R6: fresh sample, restart from the first bit
      t_frame(10'h0AA, 1'b0, 2'b10);
   endtask

   task automatic t_idle_clocks;
      for (int k = 0; k < 4; k++) begin
         sclk_rise;
         sclk_fall;
         chk("R7", "deselected sclk sdo_en", int'(e_dual), 0);
         chk("R7", "deselected sclk bit_cnt", int'(c_dual), 0);
      end
      t_frame(10'h1C3, 1'b1, 2'b01);
   endtask

   initial begin
      t_reset;
      t_frame(10'h3FF, 1'b0, 2'b00);
      t_frame(10'h000, 1'b1, 2'b11);
      t_frame(10'h2A5, 1'b1, 2'b10);
      t_frame(10'h15A, 1'b0, 2'b01);
      t_abort;
      t_idle_clocks;
      finish_run;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run;
   end
endmodule